// File: doc/BRIEF.md
# Two-Stage Watchdog Timer

This block is a countdown watchdog with two levels of escalation. Software sets a timeout value, reloads the counter through a kick register and must kick it again before the count runs out. When the count first runs out, the block emits a one-cycle management event and sets a sticky first-stage flag. The counter then reloads itself from the timeout value. If it runs out again before a kick, a second-stage flag is set. Unless the `no_reboot` input is high, a platform reset pulse of fixed length is also driven.

Software reaches the block through a word-wide register port with four addresses. A write-once lock protects the run-enable bit. A halt bit freezes the counter, so no expiry can have any effect while it is set. A two-bit boot-policy field is plain storage for firmware and has no effect on the hardware. Two synchronous resets are kept apart. The core reset clears the controls, the timeout, the counter and the first-stage flag. The resume reset is the only reset that clears the second-stage flag.

Top module: `wdog_escalate`

## Requirements
- R1: After the counter holds T with counting active, the count runs out on the (T+1)th following clock edge. In the cycle after that edge, `smi_evt` is high for exactly one cycle and the first-stage flag (status bit 0) is 1. The counter reloads itself to T on that same edge.
- R2: If the count runs out a second time, with status bit 0 still set and no kick since the previous expiry, status bit 1 becomes 1 and `smi_evt` pulses again.
- R3: `plat_rst` goes high in the same cycle in which status bit 1 changes from 0 to 1, provided `no_reboot` is 0 at that edge. It then stays high for exactly RST_LEN (default 16) cycles. If `no_reboot` is 1 at that edge, `plat_rst` stays low.
- R4: Writing 1 to a status bit (address 1) clears it, and writing 0 leaves it unchanged. Status bit 1 survives `rst_core` and is cleared by `rst_resume`.
- R5: While halt (control bit 1) is 1 or enable (control bit 0) is 0, the counter holds its value and no event, flag or reset is produced.
- R6: Once the lock bit (control bit 2) is 1, software cannot clear it and writes to the enable bit are ignored. Only `rst_core` returns both to 0.
- R7: The policy field (control bits 5:4) reads back as written and has no effect on counting or outputs.
- R8: After reset every register reads 0 and both outputs are low. Reserved bits (control 31:6 and 3, status 31:2, timeout above CNT_W) read 0 and ignore writes.
- R9: Any write to address 3 loads the counter from the timeout register (address 2) and restarts the sequence at the first stage. A kick captured on the edge where the count would run out takes priority, so no event occurs on that edge.
- R10: A read of address 3 returns the current count. Read data appears in the cycle after `rd_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_core | input | 1 | Synchronous core reset, active high |
| rst_resume | input | 1 | Synchronous resume reset, active high; clears the second-stage flag |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | 2 | Register address: 0 control, 1 status, 2 timeout, 3 kick/count |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| no_reboot | input | 1 | When high, a second expiry does not drive the reset pulse |
| smi_evt | output | 1 | One-cycle management event on every expiry |
| plat_rst | output | 1 | Platform reset pulse, RST_LEN cycles long |

## Verification
The two functions that can meet in one cycle are a software kick and an expiry of the counter. The bench first lets the count run down to zero with counting enabled. It then schedules a kick so that the kick is captured on the very edge where the expiry would occur. The scoreboard expects no event on that edge and expects the first event exactly T+1 cycles after the kick. Any event seen at the old expiry time is reported as an unexpected item.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  typedef enum logic [1:0] {
    REG_CTRL = 2'd0,
    REG_STAT = 2'd1,
    REG_TMO  = 2'd2,
    REG_KICK = 2'd3
  } wd_reg_e;

  localparam int BIT_EN     = 0;
  localparam int BIT_HALT   = 1;
  localparam int BIT_LOCK   = 2;
  localparam int POL_LO     = 4;
  localparam int POL_W      = 2;
  localparam int BIT_FIRST  = 0;
  localparam int BIT_SECOND = 1;
endpackage

// File: rtl/wdog_regs.sv
module wdog_regs
  import wdog_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_core,
  input  logic              rst_resume,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              first_hit,
  input  logic              second_hit,
  output logic              run,
  output logic [CNT_W-1:0]  timeout_val,
  output logic              reload_stb,
  output logic              first_to,
  output logic              second_to,
  output logic [DATA_W-1:0] rd_data
);
  logic             en_q, halt_q, lock_q;
  logic [POL_W-1:0] pol_q;
  logic [CNT_W-1:0] tmo_q;
  logic             first_q, second_q;
  logic [DATA_W-1:0] rd_q, rd_mux;
  logic wr_ctrl, wr_stat, wr_tmo;
  logic unused_hi;

  assign unused_hi  = ^wr_data[DATA_W-1:CNT_W];
  assign wr_ctrl    = wr_en && (addr == REG_CTRL);
  assign wr_stat    = wr_en && (addr == REG_STAT);
  assign wr_tmo     = wr_en && (addr == REG_TMO);
  assign reload_stb = wr_en && (addr == REG_KICK);

  // control and timeout: core well
  always_ff @(posedge clk) begin
    if (rst_core) begin
      en_q   <= 1'b0;
      halt_q <= 1'b0;
      lock_q <= 1'b0;
      pol_q  <= '0;
      tmo_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        halt_q <= wr_data[BIT_HALT];
        pol_q  <= wr_data[POL_LO +: POL_W];
        lock_q <= lock_q | wr_data[BIT_LOCK];
        if (!lock_q) en_q <= wr_data[BIT_EN];
      end
      if (wr_tmo) tmo_q <= wr_data[CNT_W-1:0];
    end
  end

  // first-stage flag: hardware set wins over write-1-to-clear
  always_ff @(posedge clk) begin
    if (rst_core)                          first_q <= 1'b0;
    else if (first_hit || second_hit)      first_q <= 1'b1;
    else if (wr_stat && wr_data[BIT_FIRST]) first_q <= 1'b0;
  end

  // second-stage flag: resume well only
  always_ff @(posedge clk) begin
    if (rst_resume)                          second_q <= 1'b0;
    else if (second_hit)                     second_q <= 1'b1;
    else if (wr_stat && wr_data[BIT_SECOND]) second_q <= 1'b0;
  end

  always_comb begin
    rd_mux = '0;
    case (addr)
      REG_CTRL: begin
        rd_mux[BIT_EN]             = en_q;
        rd_mux[BIT_HALT]           = halt_q;
        rd_mux[BIT_LOCK]           = lock_q;
        rd_mux[POL_LO +: POL_W]    = pol_q;
      end
      REG_STAT: begin
        rd_mux[BIT_FIRST]  = first_q;
        rd_mux[BIT_SECOND] = second_q;
      end
      REG_TMO:  rd_mux[CNT_W-1:0] = tmo_q;
      default:  rd_mux[CNT_W-1:0] = cnt;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst_core)   rd_q <= '0;
    else if (rd_en) rd_q <= rd_mux;
  end

  assign run         = en_q && !halt_q;
  assign timeout_val = tmo_q;
  assign first_to    = first_q;
  assign second_to   = second_q;
  assign rd_data     = rd_q;

  a_r6_lock_sticky: assert property (@(posedge clk) disable iff (rst_core)
    lock_q |=> lock_q);
  a_r6_enable_frozen: assert property (@(posedge clk) disable iff (rst_core)
    lock_q |=> $stable(en_q));
  a_r4_second_hold: assert property (@(posedge clk) disable iff (rst_resume)
    (second_q && !(wr_stat && wr_data[BIT_SECOND])) |=> second_q);
endmodule

// File: rtl/wdog_count.sv
module wdog_count #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_core,
  input  logic             run,
  input  logic             reload_stb,
  input  logic [CNT_W-1:0] timeout_val,
  input  logic             first_to,
  output logic [CNT_W-1:0] cnt,
  output logic             first_hit,
  output logic             second_hit,
  output logic             smi
);
  logic [CNT_W-1:0] cnt_q;
  logic             stage2_q, smi_q, expire;

  // a kick in the same cycle masks the expiry
  assign expire     = run && (cnt_q == '0) && !reload_stb;
  assign second_hit = expire && stage2_q && first_to;
  assign first_hit  = expire && !second_hit;

  always_ff @(posedge clk) begin
    if (rst_core)        cnt_q <= '0;
    else if (reload_stb) cnt_q <= timeout_val;
    else if (expire)     cnt_q <= timeout_val;
    else if (run)        cnt_q <= cnt_q - 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_core || reload_stb) stage2_q <= 1'b0;
    else if (expire)            stage2_q <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst_core) smi_q <= 1'b0;
    else          smi_q <= expire;
  end

  assign cnt = cnt_q;
  assign smi = smi_q;

  a_r9_reload_loads: assert property (@(posedge clk) disable iff (rst_core)
    reload_stb |=> cnt_q == $past(timeout_val));
  a_r5_halt_freeze: assert property (@(posedge clk) disable iff (rst_core)
    (!run && !reload_stb) |=> ($stable(cnt_q) && !smi_q));
  a_r1_event_single: assert property (@(posedge clk) disable iff (rst_core)
    (smi_q && cnt_q != '0) |=> !smi_q);
endmodule

// File: rtl/wdog_rst_stretch.sv
module wdog_rst_stretch #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_core,
  input  logic trigger,
  input  logic no_reboot,
  output logic rst_out
);
  localparam int CW = $clog2(RST_LEN + 1);
  logic [CW-1:0] left_q;
  logic          fire;

  assign fire = trigger && !no_reboot && (left_q == '0);

  always_ff @(posedge clk) begin
    if (rst_core)            left_q <= '0;
    else if (fire)           left_q <= CW'(RST_LEN);
    else if (left_q != '0)   left_q <= left_q - 1'b1;
  end

  assign rst_out = (left_q != '0);

  a_r3_gated: assert property (@(posedge clk) disable iff (rst_core)
    (trigger && no_reboot && left_q == '0) |=> !rst_out);
  a_r3_holds: assert property (@(posedge clk) disable iff (rst_core)
    $rose(rst_out) |=> rst_out);
endmodule

// File: rtl/wdog_escalate.sv
module wdog_escalate #(
  parameter int CNT_W   = 16,
  parameter int RST_LEN = 16,
  parameter int DATA_W  = 32
) (
  input  logic              clk,
  input  logic              rst_core,
  input  logic              rst_resume,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  input  logic              no_reboot,
  output logic              smi_evt,
  output logic              plat_rst
);
  logic [CNT_W-1:0] cnt, timeout_val;
  logic run, reload_stb, first_to, second_to, first_hit, second_hit;
  logic second_new;

  wdog_regs #(.CNT_W(CNT_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_core(rst_core), .rst_resume(rst_resume),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .cnt(cnt), .first_hit(first_hit), .second_hit(second_hit),
    .run(run), .timeout_val(timeout_val), .reload_stb(reload_stb),
    .first_to(first_to), .second_to(second_to), .rd_data(rd_data)
  );

  wdog_count #(.CNT_W(CNT_W)) u_count (
    .clk(clk), .rst_core(rst_core), .run(run), .reload_stb(reload_stb),
    .timeout_val(timeout_val), .first_to(first_to), .cnt(cnt),
    .first_hit(first_hit), .second_hit(second_hit), .smi(smi_evt)
  );

  assign second_new = second_hit && !second_to;

  wdog_rst_stretch #(.RST_LEN(RST_LEN)) u_rst (
    .clk(clk), .rst_core(rst_core), .trigger(second_new),
    .no_reboot(no_reboot), .rst_out(plat_rst)
  );
endmodule

// File: tb/tb_wdog_escalate.sv
module tb_wdog_escalate;
  logic clk = 1'b0;
  logic rst_core = 1'b1, rst_resume = 1'b1;
  logic wr_en = 1'b0, rd_en = 1'b0, no_reboot = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;
  logic smi_evt, plat_rst;

  int cyc = 0, errors = 0, checks = 0;
  int exp_kind[$];
  int exp_cyc[$];
  int rlen = 0;
  logic rst_prev = 1'b0;
  int E, E2;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wdog_escalate dut (
    .clk(clk), .rst_core(rst_core), .rst_resume(rst_resume),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wr_data(wr_data),
    .rd_data(rd_data), .no_reboot(no_reboot),
    .smi_evt(smi_evt), .plat_rst(plat_rst)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard: kind 0 = management event, kind 1 = reset rise
  task automatic expect_evt(input int kind, input int at);
    exp_kind.push_back(kind);
    exp_cyc.push_back(at);
  endtask

  task automatic sb_take(input int kind);
    if (exp_kind.size() == 0) begin
      chk(1'b0, "R9 unexpected event kind", kind, -1);
    end else begin
      int k, c;
      k = exp_kind.pop_front();
      c = exp_cyc.pop_front();
      chk(k == kind, kind ? "R3 event kind" : "R1/R2 event kind", kind, k);
      chk(c == cyc, kind ? "R3 reset cycle" : "R1/R2 event cycle", cyc, c);
    end
  endtask

  always @(negedge clk) begin
    if (!rst_core) begin
      if (smi_evt) sb_take(0);
      if (plat_rst && !rst_prev) sb_take(1);
      if (plat_rst) rlen++;
      else if (rst_prev) begin
        chk(rlen == 16, "R3 pulse length", rlen, 16);
        rlen = 0;
      end
      rst_prev = plat_rst;
    end
  end

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [31:0] exp, input string req);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    chk(rd_data == exp, req, rd_data, exp);
  endtask

  task automatic wait_cyc(input int target);
    while (cyc != target) @(negedge clk);
  endtask

  task automatic pulse_reset(input bit core, input bit resume);
    rst_core = core; rst_resume = resume;
    repeat (2) @(negedge clk);
    rst_core = 1'b0; rst_resume = 1'b0;
    rst_prev = 1'b0; rlen = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_core = 1'b0; rst_resume = 1'b0;
    // R8 reset state
    chk(plat_rst == 1'b0 && smi_evt == 1'b0, "R8 outputs after reset", {plat_rst, smi_evt}, 0);
    rd(2'd0, 32'h0, "R8 control reset");
    rd(2'd1, 32'h0, "R8 status reset");
    rd(2'd2, 32'h0, "R8 timeout reset");
    rd(2'd3, 32'h0, "R10 count reset");
    // R7 policy stored, no counting with enable 0
    wr(2'd0, 32'h20);
    rd(2'd0, 32'h20, "R7 policy readback");

    // R1, R2, R3 full escalation
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd0);
    rd(2'd3, 32'd5, "R10 count after kick");
    wr(2'd0, 32'h21);
    E = cyc;
    expect_evt(0, E + 6);
    expect_evt(0, E + 12);
    expect_evt(1, E + 12);
    wait_cyc(E + 12);
    wr(2'd0, 32'h23);
    repeat (20) @(negedge clk);
    rd(2'd1, 32'h3, "R2 both flags set");
    rd(2'd3, 32'd4, "R5 count frozen by halt");
    repeat (10) @(negedge clk);
    rd(2'd3, 32'd4, "R5 count still frozen");
    rd(2'd0, 32'h23, "R7 policy kept");

    // R4 write-1-to-clear and reset wells
    wr(2'd1, 32'h0);
    rd(2'd1, 32'h3, "R4 write 0 no effect");
    wr(2'd1, 32'h1);
    rd(2'd1, 32'h2, "R4 clear first flag");
    pulse_reset(1'b1, 1'b0);
    rd(2'd1, 32'h2, "R4 second survives core reset");
    pulse_reset(1'b0, 1'b1);
    rd(2'd1, 32'h0, "R4 resume reset clears second");
    pulse_reset(1'b1, 1'b0);

    // R9 kick on the expiry edge; R3 no_reboot gating
    no_reboot = 1'b1;
    wr(2'd2, 32'd5);
    wr(2'd3, 32'd0);
    wr(2'd0, 32'h01);
    E = cyc;
    wait_cyc(E + 5);
    wr(2'd3, 32'd0);
    E2 = cyc;
    chk(E2 == E + 6, "R9 kick edge", E2, E + 6);
    expect_evt(0, E2 + 6);
    expect_evt(0, E2 + 12);
    wait_cyc(E2 + 12);
    wr(2'd0, 32'h03);
    repeat (20) @(negedge clk);
    rd(2'd1, 32'h3, "R3 second set with no_reboot");
    chk(plat_rst == 1'b0, "R3 no reset with no_reboot", plat_rst, 0);
    no_reboot = 1'b0;

    // R6 lock
    wr(2'd0, 32'h07);
    rd(2'd0, 32'h07, "R6 lock set");
    wr(2'd0, 32'h02);
    rd(2'd0, 32'h07, "R6 enable and lock held");
    pulse_reset(1'b1, 1'b0);
    rd(2'd0, 32'h00, "R6 core reset clears lock");
    rd(2'd1, 32'h2, "R4 second survives core reset again");
    pulse_reset(1'b0, 1'b1);

    // R8 reserved bits
    wr(2'd0, 32'hFFFF_FFC8);
    rd(2'd0, 32'h0, "R8 control reserved");
    wr(2'd2, 32'hFFFF_0000);
    rd(2'd2, 32'h0, "R8 timeout reserved");
    wr(2'd1, 32'hFFFF_FFFC);
    rd(2'd1, 32'h0, "R8 status reserved");

    repeat (10) @(negedge clk);
    chk(exp_kind.size() == 0, "R2 pending scoreboard items", exp_kind.size(), 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 0);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule